// File: doc/BRIEF.md
# Serial Flash Program and Erase Sequencer

This block is the write-side front end of a serial-interface flash memory. A host selects it by pulling the chip-select low and clocks in a frame on the serial data input. Each bit is taken on the rising serial clock, most significant bit first. The block understands three frames. The first is a write-enable opcode that arms the write latch. The second is a page-program frame: an opcode, a 24-bit address and a stream of data bytes. The third is a sector-erase frame: an opcode and a 24-bit address.

The serial pins are brought into the system clock domain through two-stage synchronizers. Page data collects in a one-page staging buffer. The column pointer wraps inside the page. When the frame ends cleanly, the block starts a self-timed busy period. During that period it sweeps the target page or sector through a byte-wide write port into an external array model. A program AND-combines each new byte with the byte already stored. An erase writes all ones. An external protection input gives the permit decision for the address of the frame. The write-in-progress and write-enable flags are brought out for status reads.

Top module: `flash_pe_seq`

## Requirements
- R1: While reset is asserted and after its release, before any frame, `wip`, `wel` and `mem_we` are 0.
- R2: A frame of exactly 8 bits carrying 06h sets `wel` to 1.
- R3: A frame carrying F2h, a 24-bit address and at least one data byte programs the page at address[23:8]. Data byte n goes to column (address[7:0] + n) mod 256, so it wraps inside the page. Only the columns that received data are written, in ascending column order. Each written value is the new byte ANDed with the stored byte.
- R4: When more than 256 data bytes arrive in one program frame, each column keeps the last byte sent to it, so the final 256 bytes are the ones that land.
- R5: A frame of exactly 32 bits carrying 20h and an address writes FFh to every byte of the SECTOR_BYTES-aligned sector containing that address, in ascending address order.
- R6: A frame whose total bit count is not a multiple of 8, or whose byte count does not fit its opcode (program: at least 5; erase: exactly 4; write-enable: exactly 1), causes no write, does not raise `wip` and leaves `wel` unchanged.
- R7: A program or erase frame is dropped when `wel` is 0.
- R8: A program or erase frame is dropped, and `wel` is kept, when `tgt_locked` is 1 at the frame end. `tgt_addr` carries the frame's 24-bit address at that moment.
- R9: An accepted program keeps `wip` at 1 for exactly T_PP clock cycles, and an accepted erase for exactly T_SE. All array writes happen while `wip` is 1.
- R10: `wel` returns to 0 after the last array write of a busy period and before `wip` falls.
- R11: A frame whose end is acted on while `wip` is 1 is ignored, write-enable included. A program frame with any byte completing while `wip` is 1 is never executed.
- R12: The end of a frame is acted on at the third system clock edge after the chip-select rises. The `wip` value held just before that edge decides whether the frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock, data taken on rising edge |
| si | input | 1 | Serial data in, MSB first |
| tgt_locked | input | 1 | 1 when the address on `tgt_addr` is write-protected |
| tgt_addr | output | 24 | Address collected from the current or last frame |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 24 | Array byte address for read and write |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data for `mem_addr`, combinational |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The busy period can end in the same clock cycle in which a new frame end is acted on. In that cycle, the clearing of `wip` and the decision to ignore the incoming frame collide. The bench provokes this by starting a program and then shifting a write-enable opcode during the busy period. It then raises the chip-select at clock offsets chosen from the measured rise of `wip`, so that the third edge after the rise lands one cycle before, exactly on, and one cycle after the busy period's last cycle. It judges the outcome through `wel`: the enable must be lost in the first two placements and take effect only in the third.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'hF2;
    localparam logic [7:0] OP_ERASE = 8'h20;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SWEEP = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

endpackage

// File: rtl/flash_spi_rx.sv
module flash_spi_rx #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             si,
    output logic             byte_vld,
    output logic [7:0]       byte_val,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             frame_end,
    output logic             frame_aligned
);

    typedef struct packed {
        logic [2:0]       cs_p;
        logic [2:0]       ck_p;
        logic [1:0]       si_p;
        logic [2:0]       bits;
        logic [6:0]       shr;
        logic [CNT_W-1:0] nbytes;
    } rx_t;

    rx_t rx_d, rx_q;
    logic ck_rise;
    logic active;

    always_comb begin
        rx_d      = rx_q;
        rx_d.cs_p = {rx_q.cs_p[1:0], cs_n};
        rx_d.ck_p = {rx_q.ck_p[1:0], sclk};
        rx_d.si_p = {rx_q.si_p[0], si};

        ck_rise       = rx_q.ck_p[1] & ~rx_q.ck_p[2];
        active        = ~rx_q.cs_p[1];
        byte_vld      = 1'b0;
        byte_val      = {rx_q.shr, rx_q.si_p[1]};
        byte_cnt      = rx_q.nbytes;
        frame_end     = rx_q.cs_p[1] & ~rx_q.cs_p[2];
        frame_aligned = (rx_q.bits == 3'd0);

        if (!active) begin
            rx_d.bits   = 3'd0;
            rx_d.nbytes = '0;
        end else if (ck_rise) begin
            rx_d.bits = 3'(rx_q.bits + 3'd1);
            rx_d.shr  = {rx_q.shr[5:0], rx_q.si_p[1]};
            if (rx_q.bits == 3'd7) begin
                byte_vld = 1'b1;
                if (rx_q.nbytes != '1) begin
                    rx_d.nbytes = CNT_W'(rx_q.nbytes + 1'b1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{cs_p: 3'b111, ck_p: 3'b000, si_p: 2'b00, bits: 3'd0,
                      shr: 7'd0, nbytes: '0};
        end else begin
            rx_q <= rx_d;
        end
    end

endmodule

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
    parameter  int PAGE_BYTES = 256,
    localparam int PG_W       = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [PG_W-1:0] wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [PG_W-1:0] rd_idx,
    output logic            rd_vld,
    output logic [7:0]      rd_data
);

    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_d, vld_q;

    always_comb begin
        vld_d = vld_q;
        if (clr) begin
            vld_d = '0;
        end else if (wr_en) begin
            vld_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_data = data_q[rd_idx];

endmodule

// File: rtl/flash_busy_seq.sv
module flash_busy_seq
    import flash_pe_pkg::*;
#(
    parameter  int PAGE_BYTES   = 256,
    parameter  int SECTOR_BYTES = 4096,
    parameter  int T_PP         = 400,
    parameter  int T_SE         = 5000,
    localparam int PG_W         = $clog2(PAGE_BYTES),
    localparam int SEC_W        = $clog2(SECTOR_BYTES),
    localparam int TMAX         = (T_SE > T_PP) ? T_SE : T_PP,
    localparam int TMR_W        = $clog2(TMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_erase,
    input  logic [23:0]     start_addr,
    output logic [PG_W-1:0] buf_idx,
    input  logic            buf_vld,
    input  logic [7:0]      buf_data,
    output logic            mem_we,
    output logic [23:0]     mem_addr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata,
    output logic            wip,
    output logic            wel_clr,
    output logic            job_erase
);

    typedef struct packed {
        phase_e            ph;
        logic              erase;
        logic [23:0]       base;
        logic [SEC_W-1:0]  idx;
        logic [TMR_W-1:0]  tmr;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [SEC_W-1:0] last_idx;
    logic [TMR_W-1:0] t_end;

    always_comb begin
        sq_d      = sq_q;
        mem_we    = 1'b0;
        wel_clr   = 1'b0;
        buf_idx   = sq_q.idx[PG_W-1:0];
        mem_addr  = sq_q.erase ? {sq_q.base[23:SEC_W], sq_q.idx}
                               : {sq_q.base[23:PG_W], sq_q.idx[PG_W-1:0]};
        mem_wdata = sq_q.erase ? 8'hFF : (mem_rdata & buf_data);
        last_idx  = sq_q.erase ? SEC_W'(SECTOR_BYTES - 1) : SEC_W'(PAGE_BYTES - 1);
        t_end     = sq_q.erase ? TMR_W'(T_SE - 1) : TMR_W'(T_PP - 1);

        unique case (sq_q.ph)
            PH_IDLE: begin
                if (start) begin
                    sq_d.ph    = PH_SWEEP;
                    sq_d.erase = start_erase;
                    sq_d.base  = start_addr;
                    sq_d.idx   = '0;
                    sq_d.tmr   = '0;
                end
            end
            PH_SWEEP: begin
                mem_we   = sq_q.erase | buf_vld;
                sq_d.tmr = TMR_W'(sq_q.tmr + 1'b1);
                sq_d.idx = SEC_W'(sq_q.idx + 1'b1);
                if (sq_q.idx == last_idx) begin
                    sq_d.ph = PH_HOLD;
                    wel_clr = 1'b1;
                end
            end
            PH_HOLD: begin
                if (sq_q.tmr == t_end) begin
                    sq_d.ph = PH_IDLE;
                end else begin
                    sq_d.tmr = TMR_W'(sq_q.tmr + 1'b1);
                end
            end
            default: sq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{ph: PH_IDLE, erase: 1'b0, base: 24'd0, idx: '0, tmr: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign wip       = (sq_q.ph != PH_IDLE);
    assign job_erase = sq_q.erase;

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_pe_pkg::*;
#(
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    parameter int T_PP         = 400,
    parameter int T_SE         = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        si,
    input  logic        tgt_locked,
    output logic [23:0] tgt_addr,
    output logic        mem_we,
    output logic [23:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        wip,
    output logic        wel
);

    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int CNT_W = 3;

    typedef struct packed {
        logic [7:0]      op;
        logic [23:0]     addr;
        logic [PG_W-1:0] col;
        logic            wel;
        logic            taint;
    } ctl_t;

    ctl_t ct_d, ct_q;

    logic             byte_vld;
    logic [7:0]       byte_val;
    logic [CNT_W-1:0] byte_cnt;
    logic             frame_end;
    logic             frame_aligned;
    logic             buf_clr;
    logic             buf_wr;
    logic [PG_W-1:0]  buf_idx;
    logic             buf_vld;
    logic [7:0]       buf_data;
    logic             start;
    logic             start_erase;
    logic             wel_clr;
    logic             job_erase;

    flash_spi_rx #(.CNT_W(CNT_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .si            (si),
        .byte_vld      (byte_vld),
        .byte_val      (byte_val),
        .byte_cnt      (byte_cnt),
        .frame_end     (frame_end),
        .frame_aligned (frame_aligned)
    );

    flash_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_idx  (ct_q.col),
        .wr_data (byte_val),
        .rd_idx  (buf_idx),
        .rd_vld  (buf_vld),
        .rd_data (buf_data)
    );

    flash_busy_seq #(
        .PAGE_BYTES   (PAGE_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .T_PP         (T_PP),
        .T_SE         (T_SE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_erase (start_erase),
        .start_addr  (ct_q.addr),
        .buf_idx     (buf_idx),
        .buf_vld     (buf_vld),
        .buf_data    (buf_data),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .wip         (wip),
        .wel_clr     (wel_clr),
        .job_erase   (job_erase)
    );

    always_comb begin
        ct_d        = ct_q;
        buf_clr     = 1'b0;
        buf_wr      = 1'b0;
        start       = 1'b0;
        start_erase = 1'b0;

        if (byte_vld) begin
            if (byte_cnt == 3'd0) begin
                ct_d.op = byte_val;
                if (byte_val == OP_PROG) begin
                    if (wip) ct_d.taint = 1'b1;
                    else     buf_clr    = 1'b1;
                end
            end else if (byte_cnt <= 3'd3) begin
                ct_d.addr = {ct_q.addr[15:0], byte_val};
                if (byte_cnt == 3'd3) begin
                    ct_d.col = byte_val[PG_W-1:0];
                end
            end else if (ct_q.op == OP_PROG) begin
                if (wip) begin
                    ct_d.taint = 1'b1;
                end else begin
                    buf_wr   = 1'b1;
                    ct_d.col = PG_W'(ct_q.col + 1'b1);
                end
            end
        end

        if (wel_clr) begin
            ct_d.wel = 1'b0;
        end

        if (frame_end) begin
            ct_d.op    = 8'h00;
            ct_d.taint = 1'b0;
            if (frame_aligned && !wip && !ct_q.taint) begin
                if (ct_q.op == OP_WREN && byte_cnt == 3'd1) begin
                    ct_d.wel = 1'b1;
                end else if (ct_q.op == OP_PROG && byte_cnt >= 3'd5 &&
                             ct_q.wel && !tgt_locked) begin
                    start = 1'b1;
                end else if (ct_q.op == OP_ERASE && byte_cnt == 3'd4 &&
                             ct_q.wel && !tgt_locked) begin
                    start       = 1'b1;
                    start_erase = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '{op: 8'h00, addr: 24'd0, col: '0, wel: 1'b0, taint: 1'b0};
        end else begin
            ct_q <= ct_d;
        end
    end

    assign tgt_addr = ct_q.addr;
    assign wel      = ct_q.wel;

endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wip,
    input logic       wel,
    input logic       mem_we,
    input logic [7:0] mem_wdata,
    input logic [7:0] mem_rdata,
    input logic       job_erase
);

    p_write_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wip);

    p_wel_gone_before_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !$past(wel));

    p_accept_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    p_prog_only_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !job_erase) |-> ((mem_wdata & ~mem_rdata) == 8'h00));

    p_wel_rises_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(wip));

endmodule

bind flash_pe_seq flash_pe_seq_chk chk_i (.*);

// File: tb/flash_pe_seq_tb_top.sv
module flash_pe_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int PAGE       = 256;
    localparam int SEC        = 1024;
    localparam int TPP        = 300;
    localparam int TSE        = 1200;
    localparam int WD_CYCLES  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        si = 1'b0;
    logic        tgt_locked;
    logic [23:0] tgt_addr;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        wip;
    logic        wel;

    typedef struct {
        logic [23:0] a;
        logic [7:0]  d;
    } wr_t;

    wr_t         sb_q[$];
    logic [7:0]  mem [4096];
    logic [7:0]  exp_mem [4096];
    logic [7:0]  tx[$];
    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          mon_cmp = 0;
    int          mon_bad = 0;
    int          wd_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_pe_seq #(
        .PAGE_BYTES   (PAGE),
        .SECTOR_BYTES (SEC),
        .T_PP         (TPP),
        .T_SE         (TSE)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .si         (si),
        .tgt_locked (tgt_locked),
        .tgt_addr   (tgt_addr),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .wip        (wip),
        .wel        (wel)
    );

    // protection map: addresses 0x800..0xBFF of each 4 KB window are locked
    always_comb tgt_locked = (tgt_addr[11:10] == 2'd2);

    // array model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
        end else if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
        end
    end
    always_comb mem_rdata = mem[mem_addr[11:0]];

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (sb_q.size() == 0) begin
                mon_cmp++;
                mon_bad++;
                $display("FAIL R6 unexpected write: actual %h<=%h expected none",
                         mem_addr, mem_wdata);
            end else begin
                wr_t e;
                e = sb_q.pop_front();
                mon_cmp++;
                if (mem_addr !== e.a || mem_wdata !== e.d) begin
                    mon_bad++;
                    $display("FAIL R3/R4/R5 write: actual %h<=%h expected %h<=%h",
                             mem_addr, mem_wdata, e.a, e.d);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 n_cmp + mon_cmp + wd_bad, n_bad + mon_bad + wd_bad);
        $finish;
    endtask

    task automatic spi_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            si = b[7-i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic frame_open();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_close();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic send_frame(input int extra);
        frame_open();
        foreach (tx[i]) spi_bits(tx[i], 8);
        if (extra > 0) spi_bits(8'hA5, extra);
        frame_close();
    endtask

    task automatic wren();
        tx = '{8'h06};
        send_frame(0);
        repeat (6) @(negedge clk);
    endtask

    task automatic build_hdr(input logic [7:0] op, input logic [23:0] a);
        tx = '{op, a[23:16], a[15:8], a[7:0]};
    endtask

    task automatic build_prog(input logic [23:0] a, input int n, input int seed);
        build_hdr(8'hF2, a);
        for (int i = 0; i < n; i++) tx.push_back(8'(seed + i * 37));
    endtask

    task automatic expect_prog(input logic [23:0] a);
        logic [7:0] bd [PAGE];
        bit         bv [PAGE];
        logic [7:0] col;
        for (int c = 0; c < PAGE; c++) bv[c] = 1'b0;
        col = a[7:0];
        for (int i = 4; i < tx.size(); i++) begin
            bd[col] = tx[i];
            bv[col] = 1'b1;
            col = 8'(col + 1);
        end
        for (int c = 0; c < PAGE; c++) begin
            if (bv[c]) begin
                wr_t e;
                logic [11:0] k;
                k   = {a[11:8], 8'(c)};
                e.a = {a[23:8], 8'(c)};
                e.d = exp_mem[k] & bd[c];
                exp_mem[k] = e.d;
                sb_q.push_back(e);
            end
        end
    endtask

    task automatic expect_erase(input logic [23:0] a);
        logic [23:0] base;
        base = a & ~24'(SEC - 1);
        for (int i = 0; i < SEC; i++) begin
            wr_t e;
            e.a = base + 24'(i);
            e.d = 8'hFF;
            exp_mem[e.a[11:0]] = 8'hFF;
            sb_q.push_back(e);
        end
    endtask

    task automatic run_busy(input int t, input string tag);
        int   w = 0;
        int   n = 0;
        logic lw = 1'b1;
        while (!wip && w < 12) begin
            @(negedge clk);
            w++;
        end
        while (wip && n < 10000) begin
            n++;
            lw = wel;
            @(negedge clk);
        end
        chk(tag, n, t, "wip high cycles (R9)");
        chk("R10", lw, 0, "wel in last busy cycle");
        chk(tag, sb_q.size(), 0, "expected writes left");
    endtask

    task automatic expect_drop(input string tag, input logic exp_wel);
        repeat (12) @(negedge clk);
        chk(tag, wip, 0, "wip after dropped frame");
        chk(tag, wel, exp_wel, "wel after dropped frame");
    endtask

    task automatic coincide(input int off);
        int nr;
        int tgt;
        wren();
        build_prog(24'h000020, 1, 0);
        tx[4] = 8'hFF;
        expect_prog(24'h000020);
        send_frame(0);
        while (!wip) @(negedge clk);
        nr  = cyc;
        tgt = nr + TPP - 3 + off;
        frame_open();
        spi_bits(8'h06, 8);
        while (cyc < tgt) @(negedge clk);
        cs_n = 1'b1;
        while (wip) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R12", wel, (off >= 1) ? 1 : 0, $sformatf("wel after frame end offset %0d", off));
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) exp_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        chk("R1", wip, 0, "wip in reset");
        chk("R1", wel, 0, "wel in reset");
        chk("R1", mem_we, 0, "mem_we in reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", wip | wel | mem_we, 0, "flags after reset");

        // R7: program without write enable
        build_prog(24'h000100, 3, 11);
        send_frame(0);
        expect_drop("R7", 1'b0);

        // R2: write enable
        wren();
        chk("R2", wel, 1, "wel after enable");

        // R3: short program, then AND over the same bytes
        build_prog(24'h000105, 3, 8'hA5);
        expect_prog(24'h000105);
        send_frame(0);
        run_busy(TPP, "R3");
        wren();
        build_prog(24'h000105, 1, 0);
        tx[4] = 8'hF0;
        expect_prog(24'h000105);
        send_frame(0);
        run_busy(TPP, "R3");

        // R3: column wrap inside the page
        wren();
        build_prog(24'h0003FE, 4, 8'h3C);
        expect_prog(24'h0003FE);
        send_frame(0);
        run_busy(TPP, "R3");

        // R4: more than a page of data
        wren();
        build_prog(24'h000210, 300, 8'h51);
        expect_prog(24'h000210);
        send_frame(0);
        run_busy(TPP, "R4");

        // R6: malformed frames
        wren();
        build_prog(24'h000140, 2, 5);
        send_frame(3);
        expect_drop("R6", 1'b1);
        build_hdr(8'h20, 24'h000456);
        tx.push_back(8'h00);
        send_frame(0);
        expect_drop("R6", 1'b1);
        tx = '{8'h20, 8'h00, 8'h04};
        send_frame(0);
        expect_drop("R6", 1'b1);

        // R5: sector erase from an inner address
        build_hdr(8'h20, 24'h000456);
        expect_erase(24'h000456);
        send_frame(0);
        run_busy(TSE, "R5");

        // R8: protected targets
        wren();
        build_hdr(8'h20, 24'h000900);
        send_frame(0);
        expect_drop("R8", 1'b1);
        build_prog(24'h000A10, 2, 9);
        send_frame(0);
        expect_drop("R8", 1'b1);

        // R11: enable frame during busy is ignored
        build_prog(24'h000010, 2, 8'h77);
        expect_prog(24'h000010);
        send_frame(0);
        wren();
        chk("R11", wip, 1, "still busy after mid-busy enable");
        while (wip) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R11", wel, 0, "wel after enable sent while busy");
        chk("R11", sb_q.size(), 0, "writes of busy program");

        // R12: frame end around the end of the busy period
        for (int off = -1; off <= 1; off++) coincide(off);
        chk("R12", sb_q.size(), 0, "writes of trial programs");

        repeat (20) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        wd_bad = 1;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule